// File: doc/BRIEF.md
# Mono Downmix and Digital Volume Stage

This block turns a stereo pair of 24-bit two's complement samples into one mono sample per frame and sets its level. The mono source is the left channel, the right channel, or the floor average of both. A signed gain code in half-decibel steps then scales the sample. The code covers -63.5 dB to +24 dB, and the scaled result saturates instead of wrapping.

A host-driven mute forces the output to zero. An automatic mute engages without host action once a programmable number of consecutive all-zero mono samples has been seen. It releases on the first non-zero sample. The upstream serial receiver presents one frame per `in_valid` pulse. The mono sample leaves two clock cycles later, marked by `out_valid`, and feeds the interpolation chain.

Top module: `mono_vol_path`

## Requirements
- R1: `src_sel` is sampled with each frame. 00 selects left, 01 selects right, and 10 or 11 selects floor((L+R)/2), formed from a 25-bit sum so that it never overflows.
- R2: `gain_code` is a signed 8-bit value in 0.5 dB steps. Code 0 is unity gain, and the output then equals the mono sample exactly.
- R3: For a clamped code c, let n = 48 - c, s = n / 12 and k = n mod 12. The output is floor(x * M / 2^(11+s)), where M = round(32768 * 10^(-k/40)). So code +48 multiplies by 16 and code -12 gives floor(x/2).
- R4: Codes above +48 act as +48, and codes below -127 act as -127.
- R5: The scaled result saturates to the range -8388608 to 8388607.
- R6: When `mute` is high in the frame's `in_valid` cycle, that frame's output sample is zero.
- R7: When `silence_limit` L is not zero, `auto_muted` rises with the output of the L-th consecutive zero mono sample and stays high while zeros continue. The first non-zero mono sample clears it and passes with its normal gain. L = 0 disables the automatic mute.
- R8: `out_valid` pulses for one cycle exactly two cycles after `in_valid`. Between pulses, `out_sample` and `auto_muted` hold their values.
- R9: The source, gain and mute controls act only in the `in_valid` cycle. A change between frames does not alter the held output or the frame already captured.
- R10: During and just after reset, `out_valid`, `out_sample` and `auto_muted` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One frame present this cycle |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| src_sel | input | 2 | Mono source select |
| gain_code | input | 8 | Signed gain code, 0.5 dB per step |
| mute | input | 1 | Host mute for this frame |
| silence_limit | input | 16 | Zero-run length that engages automatic mute, 0 = off |
| out_valid | output | 1 | Mono sample present |
| out_sample | output | 24 | Mono sample after gain and mute |
| auto_muted | output | 1 | Automatic mute state for the current output |

## Verification
Each source selection is driven with unequal, opposite-signed left and right values, so that a swapped or unaveraged path shows a different number. Odd negative sums test the floor rounding, and full-scale pairs of equal sign test the averaging headroom. Gain codes at unity, at the top, at -6 dB, one step below the top, at the floor and beyond both ends separate the mantissa index, the octave shift and the clamp. Zero runs shorter than, equal to and longer than the limit, followed by a non-zero sample, show when the automatic mute engages and releases. Controls that change between frames and just after capture show whether values are taken only at frame boundaries.

// File: rtl/mvp_pkg.sv
package mvp_pkg;
    typedef enum logic [1:0] {
        SRC_LEFT  = 2'b00,
        SRC_RIGHT = 2'b01,
        SRC_AVG   = 2'b10,
        SRC_AVG_B = 2'b11
    } src_e;

    localparam int GAIN_TOP     = 48;   // +24 dB in half-dB steps
    localparam int GAIN_FLOOR   = -127; // -63.5 dB
    localparam int STEPS_OCT    = 12;   // half-dB steps per ~6 dB
    localparam int MANT_W       = 16;
    localparam int MANT_FRAC    = 15;
    localparam int BOOST_OCT    = 4;    // +24 dB ~ 2^4
    localparam int BASE_SHIFT   = MANT_FRAC - BOOST_OCT;
    localparam int SHIFT_W      = 5;
endpackage

// File: rtl/mvp_downmix.sv
module mvp_downmix
    import mvp_pkg::*;
#(
    parameter int SMP_W = 24
) (
    input  logic signed [SMP_W-1:0] left_i,
    input  logic signed [SMP_W-1:0] right_i,
    input  logic [1:0]              sel_i,
    output logic signed [SMP_W-1:0] mono_o
);
    logic signed [SMP_W:0] sum;

    always_comb begin
        sum = {left_i[SMP_W-1], left_i} + {right_i[SMP_W-1], right_i};
        case (src_e'(sel_i))
            SRC_LEFT:  mono_o = left_i;
            SRC_RIGHT: mono_o = right_i;
            default:   mono_o = sum[SMP_W:1]; // arithmetic floor of the half
        endcase
    end
endmodule

// File: rtl/mvp_gain_lut.sv
module mvp_gain_lut
    import mvp_pkg::*;
(
    input  logic signed [7:0]   code_i,
    output logic [MANT_W-1:0]   mant_o,
    output logic [SHIFT_W-1:0]  shift_o
);
    logic [7:0] atten;
    logic [3:0] octave;
    logic [3:0] step;

    always_comb begin
        if (code_i > 8'(GAIN_TOP))
            atten = 8'd0;
        else if (code_i < 8'(GAIN_FLOOR))
            atten = 8'(GAIN_TOP - GAIN_FLOOR);
        else
            atten = 8'(GAIN_TOP) - 8'(code_i);
        octave  = 4'(atten / 8'(STEPS_OCT));
        step    = 4'(atten % 8'(STEPS_OCT));
        shift_o = SHIFT_W'(BASE_SHIFT) + SHIFT_W'(octave);
        case (step)
            4'd0:    mant_o = 16'd32768;
            4'd1:    mant_o = 16'd30935;
            4'd2:    mant_o = 16'd29205;
            4'd3:    mant_o = 16'd27571;
            4'd4:    mant_o = 16'd26029;
            4'd5:    mant_o = 16'd24573;
            4'd6:    mant_o = 16'd23198;
            4'd7:    mant_o = 16'd21900;
            4'd8:    mant_o = 16'd20675;
            4'd9:    mant_o = 16'd19519;
            4'd10:   mant_o = 16'd18427;
            default: mant_o = 16'd17396;
        endcase
    end
endmodule

// File: rtl/mvp_scale_sat.sv
module mvp_scale_sat
    import mvp_pkg::*;
#(
    parameter int SMP_W = 24
) (
    input  logic signed [SMP_W-1:0] x_i,
    input  logic [MANT_W-1:0]       mant_i,
    input  logic [SHIFT_W-1:0]      shift_i,
    output logic signed [SMP_W-1:0] y_o
);
    localparam int PW = SMP_W + MANT_W + 1;
    localparam logic signed [PW-1:0] POS_LIM = PW'((64'sd1 <<< (SMP_W-1)) - 1);
    localparam logic signed [PW-1:0] NEG_LIM = -PW'(64'sd1 <<< (SMP_W-1));

    logic signed [PW-1:0] xe, me, prod, scaled;

    always_comb begin
        xe     = {{(MANT_W+1){x_i[SMP_W-1]}}, x_i};
        me     = {{(SMP_W+1){1'b0}}, mant_i};
        prod   = xe * me;
        scaled = prod >>> shift_i;
        if (scaled > POS_LIM)
            y_o = POS_LIM[SMP_W-1:0];
        else if (scaled < NEG_LIM)
            y_o = NEG_LIM[SMP_W-1:0];
        else
            y_o = scaled[SMP_W-1:0];
    end
endmodule

// File: rtl/mono_vol_path.sv
module mono_vol_path
    import mvp_pkg::*;
#(
    parameter int SMP_W = 24,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SMP_W-1:0] in_left,
    input  logic [SMP_W-1:0] in_right,
    input  logic [1:0]       src_sel,
    input  logic [7:0]       gain_code,
    input  logic             mute,
    input  logic [CNT_W-1:0] silence_limit,
    output logic             out_valid,
    output logic [SMP_W-1:0] out_sample,
    output logic             auto_muted
);
    typedef struct packed {
        logic                    s1_vld;
        logic signed [SMP_W-1:0] s1_mono;
        logic [MANT_W-1:0]       s1_mant;
        logic [SHIFT_W-1:0]      s1_shift;
        logic                    s1_mute;
        logic                    s1_amute;
        logic [CNT_W-1:0]        zcnt;
        logic                    o_vld;
        logic [SMP_W-1:0]        o_smp;
        logic                    o_amute;
    } state_t;

    state_t st_d, st_q;

    logic signed [SMP_W-1:0] mono;
    logic [MANT_W-1:0]       mant;
    logic [SHIFT_W-1:0]      shift;
    logic signed [SMP_W-1:0] scaled;
    logic [CNT_W-1:0]        zinc;

    mvp_downmix #(.SMP_W(SMP_W)) u_mix (
        .left_i (in_left),
        .right_i(in_right),
        .sel_i  (src_sel),
        .mono_o (mono)
    );

    mvp_gain_lut u_lut (
        .code_i (gain_code),
        .mant_o (mant),
        .shift_o(shift)
    );

    mvp_scale_sat #(.SMP_W(SMP_W)) u_scale (
        .x_i    (st_q.s1_mono),
        .mant_i (st_q.s1_mant),
        .shift_i(st_q.s1_shift),
        .y_o    (scaled)
    );

    always_comb begin
        st_d        = st_q;
        st_d.s1_vld = in_valid;
        st_d.o_vld  = st_q.s1_vld;
        zinc        = (st_q.zcnt == {CNT_W{1'b1}}) ? st_q.zcnt : st_q.zcnt + 1'b1;

        // capture stage: everything a frame needs is latched together
        if (in_valid) begin
            st_d.s1_mono  = mono;
            st_d.s1_mant  = mant;
            st_d.s1_shift = shift;
            st_d.s1_mute  = mute;
            if (mono == '0) begin
                st_d.zcnt     = zinc;
                st_d.s1_amute = (silence_limit != '0) && (zinc >= silence_limit);
            end else begin
                st_d.zcnt     = '0;
                st_d.s1_amute = 1'b0;
            end
        end

        // output stage
        if (st_q.s1_vld) begin
            st_d.o_smp   = (st_q.s1_mute || st_q.s1_amute) ? '0 : scaled;
            st_d.o_amute = st_q.s1_amute;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.o_vld;
    assign out_sample = st_q.o_smp;
    assign auto_muted = st_q.o_amute;
endmodule

// File: rtl/mvp_checker.sv
module mvp_checker #(
    parameter int SMP_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             mute,
    input logic             out_valid,
    input logic [SMP_W-1:0] out_sample,
    input logic             auto_muted
);
    logic v1, v2, m1, m2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0; m1 <= 1'b0; m2 <= 1'b0;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
            if (in_valid) m1 <= mute;
            if (v1)       m2 <= m1;
        end
    end

    // R8
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v2);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_sample) && $stable(auto_muted)));

    // R6
    mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && m2) |-> (out_sample == '0));

    // R7
    amute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && auto_muted) |-> (out_sample == '0));
endmodule

bind mono_vol_path mvp_checker #(.SMP_W(SMP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mute      (mute),
    .out_valid (out_valid),
    .out_sample(out_sample),
    .auto_muted(auto_muted)
);

// File: tb/mono_vol_path_test.sv
module mono_vol_path_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_left = '0, in_right = '0;
    logic [1:0]  src_sel = '0;
    logic [7:0]  gain_code = '0;
    logic        mute = 1'b0;
    logic [15:0] silence_limit = '0;
    logic        out_valid;
    logic [23:0] out_sample;
    logic        auto_muted;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mono_vol_path uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right), .src_sel(src_sel),
        .gain_code(gain_code), .mute(mute), .silence_limit(silence_limit),
        .out_valid(out_valid), .out_sample(out_sample), .auto_muted(auto_muted)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // model from the requirement text
    function automatic longint model(input longint l, input longint r, input int sel,
                                     input int code, input bit m);
        longint x, mant, p, y;
        int c, n, s, k;
        if (sel == 0)      x = l;
        else if (sel == 1) x = r;
        else               x = (l + r) >>> 1;
        c = (code > 48) ? 48 : ((code < -127) ? -127 : code);
        n = 48 - c; s = n / 12; k = n % 12;
        mant = longint'($floor(32768.0 * (10.0 ** (-k / 40.0)) + 0.5));
        p = x * mant;
        y = p >>> (11 + s);
        if (y > 8388607) y = 8388607;
        if (y < -8388608) y = -8388608;
        return m ? 0 : y;
    endfunction

    // one frame; returns the output sample and auto-mute flag
    task automatic frame(input longint l, input longint r, input int sel, input int code,
                         input bit m, output longint y, output bit am);
        @(negedge clk);
        in_left = l[23:0]; in_right = r[23:0]; src_sel = sel[1:0];
        gain_code = code[7:0]; mute = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 no early valid", longint'(out_valid), 0);
        @(negedge clk);
        check("R8 valid at two cycles", longint'(out_valid), 1);
        y  = longint'($signed(out_sample));
        am = auto_muted;
        @(negedge clk);
        check("R8 single pulse", longint'(out_valid), 0);
    endtask

    task automatic expect_frame(input string req, input longint l, input longint r,
                                input int sel, input int code, input bit m);
        longint y; bit am;
        frame(l, r, sel, code, m, y, am);
        check(req, y, model(l, r, sel, code, m));
    endtask

    task automatic t_reset();
        check("R10 out_valid", longint'(out_valid), 0);
        check("R10 out_sample", longint'(out_sample), 0);
        check("R10 auto_muted", longint'(auto_muted), 0);
    endtask

    task automatic t_source();
        expect_frame("R1 left", 1000, -3000, 0, 0, 0);
        expect_frame("R1 right", 1000, -3000, 1, 0, 0);
        expect_frame("R1 avg", 1000, -3000, 2, 0, 0);
        expect_frame("R1 avg odd neg floor", -3, 0, 3, 0, 0);
        expect_frame("R1 avg pos full", 8388607, 8388607, 3, 0, 0);
        expect_frame("R1 avg neg full", -8388608, -8388607, 2, 0, 0);
    endtask

    task automatic t_gain();
        longint y; bit am;
        frame(-123457, 5, 0, 0, 0, y, am);
        check("R2 unity exact", y, -123457);
        frame(1000, 0, 0, 48, 0, y, am);
        check("R3 top x16", y, 16000);
        frame(-1001, 0, 0, -12, 0, y, am);
        check("R3 minus 6dB floor", y, -501);
        expect_frame("R3 one step below top", 100000, 0, 0, 47, 0);
        expect_frame("R3 floor code", 8388607, 0, 0, -127, 0);
        expect_frame("R3 mid code", -777777, 0, 1, -37, 0);
        frame(1000, 0, 0, 100, 0, y, am);
        check("R4 clamp high", y, 16000);
        expect_frame("R4 clamp low", 8388607, 0, 0, -128, 0);
        frame(1000000, 0, 0, 48, 0, y, am);
        check("R5 positive saturate", y, 8388607);
        frame(-1000000, 0, 0, 48, 0, y, am);
        check("R5 negative saturate", y, -8388608);
    endtask

    task automatic t_mute();
        longint y; bit am;
        frame(4242, 0, 0, 0, 1, y, am);
        check("R6 mute zero", y, 0);
        frame(4242, 0, 0, 0, 0, y, am);
        check("R6 unmute passes", y, 4242);
    endtask

    task automatic t_auto();
        longint y; bit am;
        silence_limit = 16'd3;
        frame(7, 0, 0, 0, 0, y, am);
        check("R7 start clear", longint'(am), 0);
        for (int i = 1; i <= 4; i++) begin
            frame(0, 0, 0, 0, 0, y, am);
            check($sformatf("R7 zero run %0d", i), longint'(am), (i >= 3) ? 1 : 0);
        end
        frame(-55, 0, 0, 0, 0, y, am);
        check("R7 release flag", longint'(am), 0);
        check("R7 release sample", y, -55);
        frame(0, 0, 0, 0, 0, y, am);
        check("R7 run restarts", longint'(am), 0);
        silence_limit = 16'd0;
        for (int i = 0; i < 5; i++) begin
            frame(0, 0, 0, 0, 0, y, am);
            check("R7 limit zero disables", longint'(am), 0);
        end
    endtask

    task automatic t_boundary();
        longint y; bit am;
        frame(1234, -4000, 0, 0, 0, y, am);
        // change controls between frames: held output must not move
        src_sel = 2'd1; gain_code = 8'd48; mute = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 held between frames", longint'($signed(out_sample)), 1234);
        check("R8 no stray valid", longint'(out_valid), 0);
        // change gain right after capture: frame keeps the captured code
        @(negedge clk);
        in_left = 24'd500; src_sel = 2'd0; gain_code = 8'd0; mute = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; gain_code = 8'd48; mute = 1'b1; in_left = 24'd9;
        @(negedge clk);
        check("R9 captured gain kept", longint'($signed(out_sample)), 500);
        gain_code = 8'd0; mute = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_source();
        t_gain();
        t_mute();
        t_auto();
        t_boundary();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule